// File: doc/BRIEF.md
# Vector Resource Request Scheduler

This block admits scalar-core threads to a shared vector unit. A core writes a control word that either asks for vector-register capacity or gives that capacity back. An ask names a vector length and a register count. The scheduler checks that request against the element capacity still free in the register file, the free thread slots, and the vector length already in use. It answers one cycle later. The answer is either a grant carrying a thread tag, or a rejection carrying the vector length and register count that could still be granted.

Vector instructions reach the block on a separate write port. Each one carries its thread tag in the top bits. An instruction that has a trailing 32-bit operand is held until that operand word arrives, and the two words are then forwarded together. An instruction whose tag does not belong to a live thread is discarded, and a sticky error flag is raised.

Top module: `vsched_top`

## Requirements
- R1: After reset no thread is live, all capacity is free, and `rsp_valid`, `fwd_valid` and `err_sticky` are low.
- R2: A control word with bit 31 = 0 is a request. Its vector length is 2^e, where e is bits [19:16], and its register count n is bits [10:0]. The request is granted when all of these hold: bits [30:20] and [15:11] are zero, n > 0, e ≤ log2(TOTAL_ELEMS), a slot is free, and n·2^e does not exceed the free elements. The response appears on the cycle after the write, with `rsp_grant`=1 and `rsp_tid` set to the lowest free slot index.
- R3: A request that fails any of the R2 conditions gives `rsp_grant`=0 and leaves all state unchanged. `rsp_vl_exp` then holds the exponent of the live threads, or the requested exponent when no thread is live. `rsp_regs` holds the free elements shifted right by that exponent.
- R4: No more than NUM_SLOTS threads are live at once. A request made while every slot is taken is rejected, even when enough capacity is free.
- R5: While a thread is live, a request whose exponent differs from that thread's exponent is rejected.
- R6: A control word with bit 31 = 1 is a release. Bits [TID_W-1:0] name the thread. The release frees that slot and its elements, and produces no response. A release of a non-live or out-of-range tag, or one with nonzero bits in [30:20] or [15:11], has no effect.
- R7: An instruction word carries its tag in bits [31:30] and a two-word flag in bit 29. A live-tag word with the flag clear is forwarded on the next cycle, with `fwd_has_opnd`=0 and `fwd_opnd`=0.
- R8: A live-tag word with the flag set produces no output. The next word on the instruction port is taken as its operand. Both words are forwarded on the cycle after the operand word, with `fwd_has_opnd`=1.
- R9: An instruction word whose tag is not live is not forwarded, and `err_sticky` is set on the next cycle. If that word has its two-word flag set, the operand word that follows is discarded as well.
- R10: Once set, `err_sticky` stays high until reset.
- R11: Elements returned by a release can be granted again. With no thread live, a request for all TOTAL_ELEMS elements is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Request or release word |
| ins_we | input | 1 | Instruction port write strobe |
| ins_wdata | input | 32 | Instruction or operand word |
| rsp_valid | output | 1 | Response to a request is present |
| rsp_grant | output | 1 | 1 = granted, 0 = rejected |
| rsp_tid | output | TID_W | Granted thread tag |
| rsp_vl_exp | output | 4 | Exponent of the vector length still available |
| rsp_regs | output | clog2(TOTAL_ELEMS+1) | Registers still available at that length |
| fwd_valid | output | 1 | Instruction forwarded this cycle |
| fwd_tid | output | TID_W | Tag of the forwarded instruction |
| fwd_insn | output | 32 | Instruction word |
| fwd_opnd | output | 32 | Operand word, or zero for a single-word instruction |
| fwd_has_opnd | output | 1 | Forwarded instruction carried an operand |
| err_sticky | output | 1 | A word with a non-live tag was seen |

## Verification
Corrupted accounting of used elements shows on the very next response. A rejection then reports the wrong `rsp_regs`, or a request that fits is refused. Both are caught by sweeping every exponent at exactly the capacity limit and one register past it. A stale live bit for a slot shows as a wrong `rsp_tid` or a missed slot-full rejection on the next request. It also shows as an instruction that is forwarded after its thread has been released, or dropped while its thread is live. An operand-pairing fault shows within two instruction writes: a lone first word is forwarded, or an operand word is forwarded as an instruction.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
   // control word layout
   localparam int CTL_KIND_BIT = 31;    // 1 = release, 0 = request
   localparam int EXP_LSB      = 16;
   localparam int EXP_W        = 4;
   localparam int CNT_W        = 11;    // register count field [10:0]
   localparam int RSV_HI_LSB   = 20;    // bits [30:20] reserved
   localparam int RSV_LO_LSB   = 11;    // bits [15:11] reserved
   localparam int RSV_LO_MSB   = 15;
   localparam int WORD_W       = 32;

   typedef enum logic { INS_IDLE = 1'b0, INS_WAIT_OPND = 1'b1 } ins_state_e;
endpackage

// File: rtl/vsched_alloc.sv
module vsched_alloc
   import vsched_pkg::*;
#(
   parameter int TOTAL_ELEMS = 1024,
   parameter int NUM_SLOTS   = 2,
   parameter int TID_W       = 2,
   localparam int ELEM_W     = $clog2(TOTAL_ELEMS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [WORD_W-1:0]    ctl_wdata,
   output logic [NUM_SLOTS-1:0] live_o,
   output logic                 rsp_valid,
   output logic                 rsp_grant,
   output logic [TID_W-1:0]     rsp_tid,
   output logic [EXP_W-1:0]     rsp_vl_exp,
   output logic [ELEM_W-1:0]    rsp_regs
);
   localparam int MAX_EXP = $clog2(TOTAL_ELEMS);

   if ((1 << MAX_EXP) != TOTAL_ELEMS) begin : g_chk_pow2
      $error("TOTAL_ELEMS must be a power of two");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << TID_W)) begin : g_chk_slots
      $error("NUM_SLOTS must fit in the tag width");
   end
   if (MAX_EXP >= (1 << EXP_W)) begin : g_chk_exp
      $error("exponent field too narrow for TOTAL_ELEMS");
   end

   // field decode
   logic              is_rel;
   logic [EXP_W-1:0]  req_e;
   logic [CNT_W-1:0]  req_n;
   logic [TID_W-1:0]  rel_tid;
   logic              rsv_ok;
   assign is_rel  = ctl_wdata[CTL_KIND_BIT];
   assign req_e   = ctl_wdata[EXP_LSB +: EXP_W];
   assign req_n   = ctl_wdata[CNT_W-1:0];
   assign rel_tid = ctl_wdata[TID_W-1:0];
   assign rsv_ok  = ~|{ctl_wdata[CTL_KIND_BIT-1:RSV_HI_LSB],
                       ctl_wdata[RSV_LO_MSB:RSV_LO_LSB]};

   logic [ELEM_W-1:0] used_a [NUM_SLOTS];
   logic [EXP_W-1:0]  cur_e;
   logic [ELEM_W-1:0] free_elems;
   logic [TID_W-1:0]  pick;
   logic              have_slot;
   logic              any_live;
   logic              rel_hit;
   logic [31:0]       need;
   logic              ok;
   logic              take;
   logic [EXP_W-1:0]  rep_e;
   int unsigned       used_sum;

   always_comb begin
      used_sum  = 0;
      have_slot = 1'b0;
      pick      = '0;
      rel_hit   = 1'b0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         used_sum = used_sum + 32'(used_a[i]);
         if (!live_o[i]) begin
            have_slot = 1'b1;
            pick      = TID_W'(i);
         end
         if (32'(rel_tid) == i && live_o[i]) rel_hit = 1'b1;
      end
   end

   assign free_elems = ELEM_W'(TOTAL_ELEMS - used_sum);
   assign any_live   = |live_o;
   assign need       = 32'(req_n) << req_e;
   assign ok         = !is_rel && rsv_ok && (req_n != '0)
                       && (req_e <= EXP_W'(MAX_EXP)) && have_slot
                       && (!any_live || req_e == cur_e)
                       && (need <= 32'(free_elems));
   assign take       = ctl_we && ok;
   assign rep_e      = any_live ? cur_e : req_e;

   logic do_rel;
   assign do_rel = ctl_we && is_rel && rsv_ok && rel_hit;

   // one register set per thread slot
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic              act_q;
      logic [ELEM_W-1:0] used_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q  <= 1'b0;
            used_q <= '0;
         end else if (take && pick == TID_W'(s)) begin
            act_q  <= 1'b1;
            used_q <= need[ELEM_W-1:0];
         end else if (do_rel && rel_tid == TID_W'(s)) begin
            act_q  <= 1'b0;
            used_q <= '0;
         end
      end
      assign live_o[s] = act_q;
      assign used_a[s] = used_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_e      <= '0;
         rsp_valid  <= 1'b0;
         rsp_grant  <= 1'b0;
         rsp_tid    <= '0;
         rsp_vl_exp <= '0;
         rsp_regs   <= '0;
      end else begin
         if (take) cur_e <= req_e;
         rsp_valid <= ctl_we && !is_rel;
         if (ctl_we && !is_rel) begin
            rsp_grant  <= ok;
            rsp_tid    <= pick;
            rsp_vl_exp <= rep_e;
            rsp_regs   <= free_elems >> rep_e;
         end
      end
   end

   // R11: accounted elements never exceed the register file
   assert_capacity_R11: assert property (@(posedge clk) disable iff (!rst_n)
      used_sum <= TOTAL_ELEMS);

   // R2: a granted tag is live once the response is visible
   assert_grant_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_grant) |-> ((live_o >> rsp_tid) & 1'b1) == 1'b1);

   // R3: a rejection leaves the slot table untouched
   assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> live_o == $past(live_o));
endmodule

// File: rtl/vsched_pair.sv
module vsched_pair
   import vsched_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int TID_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ins_we,
   input  logic [WORD_W-1:0]    ins_wdata,
   input  logic [NUM_SLOTS-1:0] live_i,
   output logic                 fwd_valid,
   output logic [TID_W-1:0]     fwd_tid,
   output logic [WORD_W-1:0]    fwd_insn,
   output logic [WORD_W-1:0]    fwd_opnd,
   output logic                 fwd_has_opnd,
   output logic                 bad_o
);
   localparam int OPND_BIT = WORD_W - 1 - TID_W;

   ins_state_e        st;
   logic [WORD_W-1:0] held_q;
   logic              held_drop_q;
   logic [TID_W-1:0]  in_tid;
   logic              known;

   assign in_tid = ins_wdata[WORD_W-1 -: TID_W];

   always_comb begin
      known = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (32'(in_tid) == i && live_i[i]) known = 1'b1;
      end
   end

   assign bad_o = ins_we && (st == INS_IDLE) && !known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= INS_IDLE;
         held_q       <= '0;
         held_drop_q  <= 1'b0;
         fwd_valid    <= 1'b0;
         fwd_tid      <= '0;
         fwd_insn     <= '0;
         fwd_opnd     <= '0;
         fwd_has_opnd <= 1'b0;
      end else begin
         fwd_valid <= 1'b0;
         if (ins_we) begin
            if (st == INS_WAIT_OPND) begin
               st <= INS_IDLE;
               if (!held_drop_q) begin
                  fwd_valid    <= 1'b1;
                  fwd_tid      <= held_q[WORD_W-1 -: TID_W];
                  fwd_insn     <= held_q;
                  fwd_opnd     <= ins_wdata;
                  fwd_has_opnd <= 1'b1;
               end
            end else if (ins_wdata[OPND_BIT]) begin
               st          <= INS_WAIT_OPND;
               held_q      <= ins_wdata;
               held_drop_q <= !known;
            end else if (known) begin
               fwd_valid    <= 1'b1;
               fwd_tid      <= in_tid;
               fwd_insn     <= ins_wdata;
               fwd_opnd     <= '0;
               fwd_has_opnd <= 1'b0;
            end
         end
      end
   end

   // R8: a paired forward only follows a held first word
   assert_pair_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_has_opnd) |-> $past(st) == INS_WAIT_OPND);

   // R9: a single-word forward belongs to a thread live when it was written
   assert_single_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_has_opnd) |-> (($past(live_i) >> fwd_tid) & 1'b1) == 1'b1);
endmodule

// File: rtl/vsched_top.sv
module vsched_top
   import vsched_pkg::*;
#(
   parameter int TOTAL_ELEMS = 1024,
   parameter int NUM_SLOTS   = 2,
   parameter int TID_W       = 2,
   localparam int ELEM_W     = $clog2(TOTAL_ELEMS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [31:0]       ctl_wdata,
   input  logic              ins_we,
   input  logic [31:0]       ins_wdata,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic [TID_W-1:0]  rsp_tid,
   output logic [3:0]        rsp_vl_exp,
   output logic [ELEM_W-1:0] rsp_regs,
   output logic              fwd_valid,
   output logic [TID_W-1:0]  fwd_tid,
   output logic [31:0]       fwd_insn,
   output logic [31:0]       fwd_opnd,
   output logic              fwd_has_opnd,
   output logic              err_sticky
);
   logic [NUM_SLOTS-1:0] live;
   logic                 bad;

   vsched_alloc #(
      .TOTAL_ELEMS(TOTAL_ELEMS), .NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .live_o(live), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
      .rsp_tid(rsp_tid), .rsp_vl_exp(rsp_vl_exp), .rsp_regs(rsp_regs)
   );

   vsched_pair #(.NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .ins_we(ins_we), .ins_wdata(ins_wdata),
      .live_i(live), .fwd_valid(fwd_valid), .fwd_tid(fwd_tid),
      .fwd_insn(fwd_insn), .fwd_opnd(fwd_opnd), .fwd_has_opnd(fwd_has_opnd),
      .bad_o(bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_sticky <= 1'b0;
      else if (bad) err_sticky <= 1'b1;
   end

   // R10: the error flag never drops without reset
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   // R9: the flag only rises after a word with a non-live tag
   assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sticky) |-> $past(ins_we));
endmodule

// File: tb/sim_vsched_top.sv
module sim_vsched_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        ins_we = 1'b0;
   logic [31:0] ins_wdata = '0;
   logic        rsp_valid, rsp_grant;
   logic [1:0]  rsp_tid;
   logic [3:0]  rsp_vl_exp;
   logic [10:0] rsp_regs;
   logic        fwd_valid, fwd_has_opnd, err_sticky;
   logic [1:0]  fwd_tid;
   logic [31:0] fwd_insn, fwd_opnd;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit m_live [2];
   int m_used [2];
   int m_e = 0;

   always #10 clk = ~clk;

   vsched_top u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ins_we(ins_we), .ins_wdata(ins_wdata), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .rsp_tid(rsp_tid), .rsp_vl_exp(rsp_vl_exp),
      .rsp_regs(rsp_regs), .fwd_valid(fwd_valid), .fwd_tid(fwd_tid),
      .fwd_insn(fwd_insn), .fwd_opnd(fwd_opnd), .fwd_has_opnd(fwd_has_opnd),
      .err_sticky(err_sticky)
   );

   task automatic chk(input bit good, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_req(input int e, input int n);
      return {1'b0, 11'b0, 4'(e), 5'b0, 11'(n)};
   endfunction

   task automatic ctl_write(input logic [31:0] w);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = w;
      @(negedge clk);
      ctl_we = 1'b0; ctl_wdata = '0;
   endtask

   task automatic ins_write(input logic [31:0] w);
      @(negedge clk);
      ins_we = 1'b1; ins_wdata = w;
      @(negedge clk);
      ins_we = 1'b0; ins_wdata = '0;
   endtask

   // request with expected result worked out from R2..R5
   task automatic do_req(input int e, input int n, input logic [31:0] extra, input string tag);
      int free, rep_e, pick;
      bit any, have, ok;
      free = 1024 - m_used[0] - m_used[1];
      any  = m_live[0] || m_live[1];
      have = 1'b0; pick = 0;
      for (int i = 1; i >= 0; i--) if (!m_live[i]) begin have = 1'b1; pick = i; end
      ok = (extra == 0) && n > 0 && e <= 10 && have && (!any || e == m_e) && ((n << e) <= free);
      rep_e = any ? m_e : e;
      ctl_write(mk_req(e, n) | extra);
      chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, rsp_valid, 1);
      chk(rsp_grant == ok, {tag, " grant"}, rsp_grant, ok);
      if (ok) begin
         chk(rsp_tid == 2'(pick), {tag, " tid"}, rsp_tid, pick);
         m_live[pick] = 1'b1; m_used[pick] = n << e; m_e = e;
      end else begin
         chk(rsp_vl_exp == 4'(rep_e), {tag, " vl_exp"}, rsp_vl_exp, rep_e);
         chk(rsp_regs == 11'(free >> rep_e), {tag, " regs"}, rsp_regs, free >> rep_e);
      end
   endtask

   task automatic do_rel(input int tid, input string tag);
      ctl_write({1'b1, 29'b0, 2'(tid)});
      chk(rsp_valid == 1'b0, {tag, " release silent"}, rsp_valid, 0);
      if (tid < 2 && m_live[tid]) begin m_live[tid] = 1'b0; m_used[tid] = 0; end
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d cycles expected=completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] w;
      m_live[0] = 0; m_live[1] = 0; m_used[0] = 0; m_used[1] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
      chk(fwd_valid == 1'b0, "R1 fwd_valid", fwd_valid, 0);
      chk(err_sticky == 1'b0, "R1 err", err_sticky, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0 && err_sticky == 1'b0, "R1 idle after reset", rsp_valid, 0);

      // R2 R3 R11 sweep of every exponent at the capacity edge
      for (int e = 0; e <= 10; e++) begin
         do_req(e, (1024 >> e) + 1, 0, "R3 over capacity");
         do_req(e, 1024 >> e, 0, "R2 full fit");
         do_req(e, 1, 0, "R3 when full");
         do_rel(0, "R11 return");
      end
      do_req(11, 1, 0, "R3 exponent too large");
      do_req(3, 0, 0, "R3 zero count");
      do_req(3, 4, 32'h0200_0000, "R3 reserved high bit");
      do_req(3, 4, 32'h0000_0800, "R3 reserved low bit");

      // R4 slot limit
      do_req(4, 8, 0, "R2 first slot");
      do_req(4, 8, 0, "R2 second slot");
      do_req(4, 1, 0, "R4 third thread");
      // R5 mismatched length
      do_rel(1, "R6 release slot1");
      do_req(5, 2, 0, "R5 other length");
      do_req(4, 2, 0, "R2 refill slot1");
      // R6 ignored releases, checked through a later rejection
      do_rel(3, "R6 out of range tag");
      ctl_write({1'b1, 4'h1, 25'b0, 2'd0});
      chk(rsp_valid == 1'b0, "R6 malformed release silent", rsp_valid, 0);
      do_req(4, 1, 0, "R6 state kept");

      // R7 single word
      ins_write({2'd0, 1'b0, 29'h0ABC_1234});
      chk(fwd_valid == 1'b1, "R7 fwd_valid", fwd_valid, 1);
      chk(fwd_tid == 2'd0 && fwd_has_opnd == 1'b0, "R7 tag/flag", fwd_tid, 0);
      chk(fwd_insn == {2'd0, 1'b0, 29'h0ABC_1234}, "R7 word", fwd_insn, {2'd0, 1'b0, 29'h0ABC_1234});
      chk(fwd_opnd == 32'd0, "R7 operand zero", fwd_opnd, 0);
      // R8 two-word
      w = {2'd1, 1'b1, 29'h0000_0777};
      ins_write(w);
      chk(fwd_valid == 1'b0, "R8 held first word", fwd_valid, 0);
      ins_write(32'hDEAD_BEEF);
      chk(fwd_valid == 1'b1 && fwd_has_opnd == 1'b1, "R8 paired forward", fwd_valid, 1);
      chk(fwd_insn == w && fwd_tid == 2'd1, "R8 first word", fwd_insn, w);
      chk(fwd_opnd == 32'hDEAD_BEEF, "R8 operand", fwd_opnd, 32'hDEAD_BEEF);
      chk(err_sticky == 1'b0, "R9 no error yet", err_sticky, 0);

      // R9 dropped words
      do_rel(1, "R6 release before drop");
      ins_write({2'd1, 1'b0, 29'h1});
      chk(fwd_valid == 1'b0, "R9 released tag dropped", fwd_valid, 0);
      chk(err_sticky == 1'b1, "R9 error set", err_sticky, 1);
      ins_write({2'd3, 1'b1, 29'h2});
      chk(fwd_valid == 1'b0, "R9 unknown two-word dropped", fwd_valid, 0);
      ins_write({2'd0, 1'b0, 29'h3});
      chk(fwd_valid == 1'b0, "R9 trailing operand discarded", fwd_valid, 0);
      ins_write({2'd0, 1'b0, 29'h4});
      chk(fwd_valid == 1'b1 && fwd_insn == {2'd0, 1'b0, 29'h4}, "R7 resumes after drop", fwd_valid, 1);
      repeat (3) @(negedge clk);
      chk(err_sticky == 1'b1, "R10 stays set", err_sticky, 1);

      // R11 full capacity after everything released
      do_rel(0, "R11 release slot0");
      do_req(0, 1024, 0, "R11 whole file");
      do_rel(0, "R11 final release");
      do_req(10, 1, 0, "R11 largest length");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule